// File: doc/BRIEF.md
# Maskable Status Interrupt Merger

This block folds three status events into a single level interrupt: a change of the link-up indication in either direction, a rollover of a statistics counter, and a transmit error. A transmit error is detected when transmit-enable drops while the transmit-success flag is low. Each event is held in its own sticky latch. A separate enable bit gates each latch into the summary interrupt.

Software writes all three enable bits with one control write. The same write acknowledges the link event. A status-read strobe clears the rollover and transmit-error latches. The link-up input is asynchronous, so it passes through a synchronizer before edge detection. The counter-rollover flag and the transmit flags are synchronous to the block clock.

Top module: `status_irq_merge`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `evt_o` is 000, `irq_o` is 0 and all three enable bits are 0. A rollover event after reset therefore leaves `irq_o` low.
- R2: A clock edge with `cfg_we` high loads the enables from `cfg_wdata`: bit 0 is link, bit 1 is rollover, bit 2 is transmit error. The new values act from the next cycle on.
- R3: A clock edge with `ctr_roll` high sets `evt_o[1]`.
- R4: A clock edge where `tx_en` was high on the previous edge, is low now, and `tx_ok` is low sets `evt_o[2]`. If `tx_ok` is high when `tx_en` drops, `evt_o[2]` is not set.
- R5: A clock edge with `stat_rd` high clears `evt_o[1]` and `evt_o[2]`. It leaves `evt_o[0]` unchanged. A new event on the same edge wins over the clear.
- R6: `irq_o` is high exactly when some bit of `evt_o` is high and its enable is high. It follows the latches without a further register stage.
- R7: A rising or falling change of `link_ok` sets `evt_o[0]`. The bit becomes visible SYNC_STAGES+1 clock edges after the input changes, and not earlier.
- R8: Every edge with `cfg_we` high clears `evt_o[0]`, whatever value is written. A link change latched on that same edge wins, and the bit stays set.
- R9: Events are latched even while their enable is 0. Setting the enable later raises `irq_o` without a new event.
- R10: After reset the synchronized link state is taken as 0. A `link_ok` that is high once reset ends counts as a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control write strobe (loads enables, acknowledges link event) |
| cfg_wdata | input | 3 | Enable bits: [0] link, [1] rollover, [2] transmit error |
| stat_rd | input | 1 | Status read strobe (clears rollover and transmit-error latches) |
| link_ok | input | 1 | Asynchronous link-up level |
| ctr_roll | input | 1 | Counter rollover flag |
| tx_en | input | 1 | Transmit enable level |
| tx_ok | input | 1 | Transmit success flag |
| evt_o | output | 3 | Sticky events: [0] link change, [1] rollover, [2] transmit error |
| irq_o | output | 1 | Summary interrupt level |

## Verification
The bench targets the same-edge races: a status read meeting a new rollover, and an acknowledging write meeting a link change. A design where the clear wins would drop an event that software never sees. The bench checks the exact cycle the link bit appears, in both directions, so an extra or a missing synchronizer stage shows up as an early or late bit. It also checks that a successful transmit end, or a status read, leaves the wrong latches alone. It resets in the middle of a run with the link already up, which exposes a design that loses or invents a link change after reset.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;
    localparam int unsigned EV_LINK  = 0;
    localparam int unsigned EV_ROLL  = 1;
    localparam int unsigned EV_TXERR = 2;
    localparam int unsigned EV_NUM   = 3;

    typedef logic [EV_NUM-1:0] ev_vec_t;

    typedef struct packed {
        ev_vec_t en;
    } top_state_t;
endpackage

// File: rtl/link_sync_edge.sv
module link_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_i,
    output logic chg_o
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-1:0] << 1} | {{(STAGES-1){1'b0}}, link_i};
        st_d.prev = st_q.sync[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chg_o = st_q.sync[LAST] ^ st_q.prev;
endmodule

// File: rtl/txerr_detect.sv
module txerr_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic tx_ok,
    output logic err_o
);
    typedef struct packed {
        logic en_prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.en_prev = tx_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_o = st_q.en_prev & ~tx_en & ~tx_ok;
endmodule

// File: rtl/evt_sticky.sv
module evt_sticky #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] evt_o
);
    typedef struct packed {
        logic [N-1:0] evt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < int'(N); i++) begin
            if (set_i[i])      st_d.evt[i] = 1'b1;
            else if (clr_i[i]) st_d.evt[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_o = st_q.evt;
endmodule

// File: rtl/status_irq_merge.sv
module status_irq_merge
    import irq_merge_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [EV_NUM-1:0] cfg_wdata,
    input  logic              stat_rd,
    input  logic              link_ok,
    input  logic              ctr_roll,
    input  logic              tx_en,
    input  logic              tx_ok,
    output logic [EV_NUM-1:0] evt_o,
    output logic              irq_o
);
    top_state_t st_d, st_q;
    logic       link_chg;
    logic       tx_err;
    ev_vec_t    ev_set, ev_clr, ev_q, en_q;

    link_sync_edge #(.STAGES(SYNC_STAGES)) u_link (
        .clk   (clk),
        .rst_n (rst_n),
        .link_i(link_ok),
        .chg_o (link_chg)
    );

    txerr_detect u_txerr (
        .clk  (clk),
        .rst_n(rst_n),
        .tx_en(tx_en),
        .tx_ok(tx_ok),
        .err_o(tx_err)
    );

    always_comb begin
        ev_set           = '0;
        ev_clr           = '0;
        ev_set[EV_LINK]  = link_chg;
        ev_set[EV_ROLL]  = ctr_roll;
        ev_set[EV_TXERR] = tx_err;
        ev_clr[EV_LINK]  = cfg_we;
        ev_clr[EV_ROLL]  = stat_rd;
        ev_clr[EV_TXERR] = stat_rd;
    end

    evt_sticky #(.N(EV_NUM)) u_sticky (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(ev_set),
        .clr_i(ev_clr),
        .evt_o(ev_q)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_we) st_d.en = cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q  = st_q.en;
    assign evt_o = ev_q;
    assign irq_o = |(ev_q & en_q);
endmodule

// File: rtl/status_irq_merge_chk.sv
module status_irq_merge_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [2:0] cfg_wdata,
    input logic       stat_rd,
    input logic       ctr_roll,
    input logic       tx_en,
    input logic       tx_ok,
    input logic       link_chg,
    input logic [2:0] en_q,
    input logic [2:0] evt_o,
    input logic       irq_o
);
    assert_enable_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (en_q == $past(cfg_wdata)));

    assert_roll_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_roll |=> evt_o[1]);

    assert_txerr_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o[2] && !$past(evt_o[2])) |-> $past(!tx_en && !tx_ok));

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !ctr_roll) |=> !evt_o[1]);

    assert_irq_has_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (evt_o != 3'b000));

    assert_ack_clears_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !link_chg) |=> !evt_o[0]);

    assert_link_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o[0] && !cfg_we) |=> evt_o[0]);
endmodule

bind status_irq_merge status_irq_merge_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .stat_rd  (stat_rd),
    .ctr_roll (ctr_roll),
    .tx_en    (tx_en),
    .tx_ok    (tx_ok),
    .link_chg (link_chg),
    .en_q     (en_q),
    .evt_o    (evt_o),
    .irq_o    (irq_o)
);

// File: tb/tb_status_irq_merge.sv
module tb_status_irq_merge;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_wdata = 3'b000;
    logic       stat_rd = 1'b0;
    logic       link_ok = 1'b0;
    logic       ctr_roll = 1'b0;
    logic       tx_en = 1'b0;
    logic       tx_ok = 1'b0;
    logic [2:0] evt_o;
    logic       irq_o;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    status_irq_merge dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .stat_rd(stat_rd), .link_ok(link_ok), .ctr_roll(ctr_roll),
        .tx_en(tx_en), .tx_ok(tx_ok), .evt_o(evt_o), .irq_o(irq_o)
    );

    // {we, wdata[2:0], rd, roll, txen, txok, exp_evt[2:0], exp_irq, req[3:0]}
    localparam int NV = 12;
    localparam logic [15:0] VEC [NV] = '{
        {1'b1, 3'b110, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 4'd2},  // R2
        {1'b0, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 3'b010, 1'b1, 4'd3},  // R3
        {1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 4'd5},  // R5
        {1'b0, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 4'd4},  // R4
        {1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 3'b000, 1'b0, 4'd4},  // R4 success
        {1'b0, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 4'd4},  // R4
        {1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 3'b100, 1'b1, 4'd4},  // R4 error
        {1'b0, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 3'b010, 1'b1, 4'd5},  // R5 set wins
        {1'b1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 3'b010, 1'b0, 4'd6},  // R6
        {1'b0, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 3'b010, 1'b0, 4'd9},  // R9
        {1'b1, 3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 3'b010, 1'b1, 4'd9},  // R9
        {1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 4'd5}   // R5
    };

    task automatic chk(input string req, input logic [2:0] exp_evt, input logic exp_irq);
        checks++;
        if (evt_o !== exp_evt || irq_o !== exp_irq) begin
            errors++;
            $display("FAIL %s: evt=%b irq=%b, expected evt=%b irq=%b",
                     req, evt_o, irq_o, exp_evt, exp_irq);
        end
    endtask

    task automatic drive(input logic we, input logic [2:0] wd, input logic rd,
                         input logic roll, input logic te, input logic tok);
        cfg_we = we; cfg_wdata = wd; stat_rd = rd;
        ctr_roll = roll; tx_en = te; tx_ok = tok;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 in reset", 3'b000, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 3'b000, 1'b0);
        drive(1'b0, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0);
        step();
        chk("R1 enables zero", 3'b010, 1'b0);
        drive(1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0);
        step();
        chk("R5 clear", 3'b000, 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][15], VEC[i][14:12], VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8]);
            step();
            chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), VEC[i][7:5], VEC[i][4]);
        end
        drive(1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);

        // link enable on
        drive(1'b1, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0);
        step();
        drive(1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
        link_ok = 1'b1;
        step(); step();
        chk("R7 not early", 3'b000, 1'b0);
        step();
        chk("R7 rising", 3'b001, 1'b1);
        drive(1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0);
        step();
        chk("R5 link kept", 3'b001, 1'b1);
        drive(1'b1, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0);
        step();
        chk("R8 ack", 3'b000, 1'b0);
        drive(1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
        link_ok = 1'b0;
        step(); step(); step();
        chk("R7 falling", 3'b001, 1'b1);
        drive(1'b1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
        step();
        chk("R8 any value", 3'b000, 1'b0);
        drive(1'b1, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0);
        step();
        drive(1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
        link_ok = 1'b1;
        step(); step();
        drive(1'b1, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0);
        step();
        chk("R8 set wins", 3'b001, 1'b1);
        drive(1'b0, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0);
        step();
        drive(1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b0;
        #1;
        chk("R1 async reset", 3'b000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step(); step(); step();
        chk("R10 link high after reset", 3'b001, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule